// File: doc/BRIEF.md
# Scanline Fetch Window Timer

This block sets the per-line timing that decides who owns the memory bus: the video fetch engine or the CPU. It counts video clocks across each scanline. At a fixed line position it pulls the CPU's active-low halt input low at once, without waiting for the current instruction to finish. It then waits out a startup latency and grants the bus to the fetch engine. At a fixed later position it cuts fetching off, whether or not work remains. It keeps the CPU halted through a shutdown latency and then releases it.

Both latencies grow when the CPU is in the middle of a bus access. They grow further when that access is stretched for a slow peripheral. Both latencies are also extended until the generated CPU clock is at its aligned phase, so the halt edges never split a CPU clock. This gives a startup of 5 to 12 clocks and a shutdown of 9 to 23 clocks.

A line-sync input re-zeroes the line count, so the window can be locked to the display's own line start. The fetch engine is expected to run only while fetch enable is high, and to drop its work when it sees the abort pulse.

Top module: `scan_dma_window`

## Requirements
- R1: The line count advances by one per clock from 0 to 453 and then wraps to 0. When line sync is high in a cycle, the count reads 0 in the next cycle.
- R2: In the cycle after the one in which the line count reads 34, halt goes low (active-low). This happens whether or not the CPU busy input is high.
- R3: The startup base latency is 5 clocks. It is 2 more if CPU busy is high, and 2 more again if busy and slow are both high. Slow alone adds nothing. Busy and slow are sampled in the cycle the count reads 34.
- R4: Fetch enable first goes high in the earliest cycle that is at least the startup base latency after halt went low and in which the CPU phase reads 1. The CPU phase is the number of clock edges since reset release, modulo 4. Fetch enable is only ever high while halt is low.
- R5: If the window is active in the cycle the count reads 413, then in the next cycle fetch enable is low and abort is high. Abort stays high for exactly one cycle.
- R6: The shutdown base latency is 9 clocks. It is 4 more if busy is high, and 7 more again if busy and slow are both high, sampled in the cycle the count reads 413. Halt returns high in the earliest cycle that is at least that many clocks after the abort cycle and in which the CPU phase reads 1.
- R7: If startup has not completed by the abort cycle, fetch enable never goes high on that line, and abort and shutdown still take place.
- R8: During reset, halt is high, fetch enable and abort are low, and the line count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | 1 | Re-zeroes the line count on the next clock |
| cpu_busy_i | input | 1 | CPU is mid bus access |
| cpu_slow_i | input | 1 | The current CPU access is stretched for a slow peripheral |
| halt_no | output | 1 | Active-low CPU halt request |
| fetch_en_o | output | 1 | Bus granted to the fetch engine |
| abort_o | output | 1 | One-cycle pulse: fetching cut off |
| line_cnt_o | output | 9 | Video clock position within the line |

## Verification
The bench sweeps all four busy/slow combinations separately at window start and at window end. Because the line length is not a multiple of the CPU clock divide, each line also lands on a different phase alignment. A design that misses the alignment would move the fetch or release edge by up to three clocks. A design that lets slow count without busy would add two or seven clocks where none belong. A second instance places the window start just ahead of the abort cycle, so startup cannot finish. There the bench checks that no fetch pulse escapes while abort still fires. A design with the wrong abort priority would show a short fetch burst after the cutoff. Line sync is pulsed mid-line, and a counter that ignored it or wrapped at the wrong count would miscompare on every cycle after that point.

// File: rtl/scan_dma_pkg.sv
`timescale 1ns/1ps
package scan_dma_pkg;

    // Window sequencer states
    typedef enum logic [2:0] {
        WS_IDLE,      // CPU owns the bus
        WS_RAMP,      // halt asserted, counting startup latency
        WS_ALIGN_UP,  // waiting for CPU clock phase before granting
        WS_FETCH,     // fetch engine owns the bus
        WS_DRAIN,     // counting shutdown latency after the cutoff
        WS_ALIGN_DN   // waiting for CPU clock phase before release
    } win_state_e;

endpackage

// File: rtl/scan_dma_line_counter.sv
`timescale 1ns/1ps
module scan_dma_line_counter #(
    parameter int unsigned LINE_LEN = 454,
    localparam int unsigned CW = $clog2(LINE_LEN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          line_sync_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (line_sync_i || cnt_q == CW'(LINE_LEN - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!line_sync_i && cnt_q == CW'(LINE_LEN - 1)) |=> (cnt_q == '0)); // R1

    AST_SYNC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_sync_i |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/scan_dma_cpu_phase.sv
`timescale 1ns/1ps
module scan_dma_cpu_phase #(
    parameter int unsigned CPU_DIV = 4,
    localparam int unsigned PW = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic phase_zero_o
);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        if (ph_q == PW'(CPU_DIV - 1)) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_zero_o = (ph_q == '0);

    AST_PHASE_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph_q == PW'(CPU_DIV - 1)) |=> phase_zero_o); // R4

endmodule

// File: rtl/scan_dma_latency.sv
`timescale 1ns/1ps
module scan_dma_latency #(
    parameter int unsigned BASE     = 5,
    parameter int unsigned BUSY_ADD = 2,
    parameter int unsigned SLOW_ADD = 2,
    parameter int unsigned W        = 5
) (
    input  logic         busy_i,
    input  logic         slow_i,
    output logic [W-1:0] lat_o
);

    // Slow only stretches an access that is actually in progress.
    always_comb begin
        lat_o = W'(BASE);
        if (busy_i) begin
            lat_o = lat_o + W'(BUSY_ADD);
            if (slow_i) begin
                lat_o = lat_o + W'(SLOW_ADD);
            end
        end
    end

endmodule

// File: rtl/scan_dma_window_fsm.sv
`timescale 1ns/1ps
module scan_dma_window_fsm
    import scan_dma_pkg::*;
#(
    parameter int unsigned CW        = 9,
    parameter int unsigned DW        = 5,
    parameter int unsigned START_CYC = 34,
    parameter int unsigned ABORT_CYC = 413
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] cnt_i,
    input  logic          phase_zero_i,
    input  logic [DW-1:0] up_lat_i,
    input  logic [DW-1:0] dn_lat_i,
    output logic          halt_no,
    output logic          fetch_en_o,
    output logic          abort_o
);

    typedef struct packed {
        win_state_e    st;
        logic [DW-1:0] dly;
        logic          halt_n;
        logic          fetch;
        logic          abort;
    } win_t;

    win_t win_d, win_q;
    logic at_start, at_abort, active;

    assign at_start = (cnt_i == CW'(START_CYC));
    assign at_abort = (cnt_i == CW'(ABORT_CYC));
    assign active   = (win_q.st == WS_RAMP) || (win_q.st == WS_ALIGN_UP) ||
                      (win_q.st == WS_FETCH);

    always_comb begin
        win_d       = win_q;
        win_d.abort = 1'b0;
        if (active && at_abort) begin
            // Hard cutoff wins over any pending startup step.
            win_d.st    = WS_DRAIN;
            win_d.dly   = dn_lat_i - DW'(1);
            win_d.abort = 1'b1;
        end else begin
            unique case (win_q.st)
                WS_IDLE: begin
                    if (at_start) begin
                        win_d.st  = WS_RAMP;
                        win_d.dly = up_lat_i - DW'(1);
                    end
                end
                WS_RAMP: begin
                    if (win_q.dly == DW'(1)) begin
                        win_d.st = WS_ALIGN_UP;
                    end else begin
                        win_d.dly = win_q.dly - DW'(1);
                    end
                end
                WS_ALIGN_UP: begin
                    if (phase_zero_i) begin
                        win_d.st = WS_FETCH;
                    end
                end
                WS_FETCH: begin
                    win_d.st = WS_FETCH;
                end
                WS_DRAIN: begin
                    if (win_q.dly == DW'(1)) begin
                        win_d.st = WS_ALIGN_DN;
                    end else begin
                        win_d.dly = win_q.dly - DW'(1);
                    end
                end
                WS_ALIGN_DN: begin
                    if (phase_zero_i) begin
                        win_d.st = WS_IDLE;
                    end
                end
                default: win_d.st = WS_IDLE;
            endcase
        end
        win_d.halt_n = (win_d.st == WS_IDLE);
        win_d.fetch  = (win_d.st == WS_FETCH);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q.st     <= WS_IDLE;
            win_q.dly    <= '0;
            win_q.halt_n <= 1'b1;
            win_q.fetch  <= 1'b0;
            win_q.abort  <= 1'b0;
        end else begin
            win_q <= win_d;
        end
    end

    assign halt_no    = win_q.halt_n;
    assign fetch_en_o = win_q.fetch;
    assign abort_o    = win_q.abort;

    AST_HALT_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_q.st == WS_IDLE && at_start) |=> !halt_no); // R2

    AST_GRANT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fetch_en_o) |-> $past(phase_zero_i)); // R4

    AST_FETCH_UNDER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_en_o |-> !halt_no); // R4

    AST_ABORT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> !abort_o); // R5

    AST_ABORT_DROPS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> (!fetch_en_o && !halt_no)); // R5

    AST_RELEASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(halt_no) |-> $past(phase_zero_i)); // R6

    AST_NO_LATE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_abort && !fetch_en_o) |=> !fetch_en_o); // R7

endmodule

// File: rtl/scan_dma_window.sv
`timescale 1ns/1ps
module scan_dma_window #(
    parameter int unsigned LINE_LEN  = 454,
    parameter int unsigned START_CYC = 34,
    parameter int unsigned ABORT_CYC = 413,
    parameter int unsigned CPU_DIV   = 4,
    parameter int unsigned UP_BASE   = 5,
    parameter int unsigned UP_BUSY   = 2,
    parameter int unsigned UP_SLOW   = 2,
    parameter int unsigned DN_BASE   = 9,
    parameter int unsigned DN_BUSY   = 4,
    parameter int unsigned DN_SLOW   = 7,
    localparam int unsigned CW       = $clog2(LINE_LEN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          line_sync_i,
    input  logic          cpu_busy_i,
    input  logic          cpu_slow_i,
    output logic          halt_no,
    output logic          fetch_en_o,
    output logic          abort_o,
    output logic [CW-1:0] line_cnt_o
);

    localparam int unsigned UP_MAX  = UP_BASE + UP_BUSY + UP_SLOW;
    localparam int unsigned DN_MAX  = DN_BASE + DN_BUSY + DN_SLOW;
    localparam int unsigned LAT_MAX = (UP_MAX > DN_MAX) ? UP_MAX : DN_MAX;
    localparam int unsigned DW      = $clog2(LAT_MAX + 1);

    logic [CW-1:0] cnt;
    logic          phase_zero;
    logic [DW-1:0] up_lat, dn_lat;

    scan_dma_line_counter #(
        .LINE_LEN (LINE_LEN)
    ) u_line (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_sync_i (line_sync_i),
        .cnt_o       (cnt)
    );

    scan_dma_cpu_phase #(
        .CPU_DIV (CPU_DIV)
    ) u_phase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .phase_zero_o (phase_zero)
    );

    scan_dma_latency #(
        .BASE     (UP_BASE),
        .BUSY_ADD (UP_BUSY),
        .SLOW_ADD (UP_SLOW),
        .W        (DW)
    ) u_up_lat (
        .busy_i (cpu_busy_i),
        .slow_i (cpu_slow_i),
        .lat_o  (up_lat)
    );

    scan_dma_latency #(
        .BASE     (DN_BASE),
        .BUSY_ADD (DN_BUSY),
        .SLOW_ADD (DN_SLOW),
        .W        (DW)
    ) u_dn_lat (
        .busy_i (cpu_busy_i),
        .slow_i (cpu_slow_i),
        .lat_o  (dn_lat)
    );

    scan_dma_window_fsm #(
        .CW        (CW),
        .DW        (DW),
        .START_CYC (START_CYC),
        .ABORT_CYC (ABORT_CYC)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cnt_i        (cnt),
        .phase_zero_i (phase_zero),
        .up_lat_i     (up_lat),
        .dn_lat_i     (dn_lat),
        .halt_no      (halt_no),
        .fetch_en_o   (fetch_en_o),
        .abort_o      (abort_o)
    );

    assign line_cnt_o = cnt;

    AST_ABORT_ON_CUTOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> (cnt == CW'(ABORT_CYC + 1) || cnt == '0)); // R5

endmodule

// File: tb/scan_dma_window_bench.sv
`timescale 1ns/1ps
module scan_dma_window_bench;

    localparam int LINE   = 454;
    localparam int START  = 34;
    localparam int ABORT  = 413;
    localparam int LSTART = 405;

    typedef enum int {EV_HALT_LO, EV_FETCH_HI, EV_FETCH_LO, EV_ABORT, EV_HALT_HI} ev_e;
    typedef struct {
        ev_e   kind;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       line_sync = 1'b0;
    logic       busy = 1'b0;
    logic       slow = 1'b0;
    logic       halt_n, fetch, abort;
    logic [8:0] cnt;
    logic       halt_n_l, fetch_l, abort_l;
    logic [8:0] cnt_l;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   exp_cnt = 0;
    bit   done = 1'b0;
    logic prev_h = 1'b1;
    logic prev_f = 1'b0;
    bit   late_exp = 1'b0;
    bit   late_seen = 1'b0;

    always #2.5 clk = ~clk;

    scan_dma_window u_scan_dma_window (
        .clk_i (clk), .rst_ni (rst_ni), .line_sync_i (line_sync),
        .cpu_busy_i (busy), .cpu_slow_i (slow),
        .halt_no (halt_n), .fetch_en_o (fetch), .abort_o (abort), .line_cnt_o (cnt)
    );

    scan_dma_window #(.START_CYC(LSTART)) u_scan_dma_window_late (
        .clk_i (clk), .rst_ni (rst_ni), .line_sync_i (line_sync),
        .cpu_busy_i (busy), .cpu_slow_i (slow),
        .halt_no (halt_n_l), .fetch_en_o (fetch_l), .abort_o (abort_l), .line_cnt_o (cnt_l)
    );

    // Reference timeline: edges since reset release and expected line count
    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc     <= 0;
            exp_cnt <= 0;
        end else begin
            cyc     <= cyc + 1;
            exp_cnt <= line_sync ? 0 : ((exp_cnt == LINE - 1) ? 0 : exp_cnt + 1);
        end
    end

    function automatic int up_lat(bit b, bit s);
        return 5 + (b ? 2 : 0) + ((b && s) ? 2 : 0);
    endfunction

    function automatic int dn_lat(bit b, bit s);
        return 9 + (b ? 4 : 0) + ((b && s) ? 7 : 0);
    endfunction

    function automatic int next_ph1(int c);
        int x = c;
        while (x % 4 != 1) x++;
        return x;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: pops expected events as the design produces them
    task automatic see(ev_e k);
        exp_t e;
        n_vec++;
        if (q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event %s at cycle %0d: actual %0d expected none",
                     k.name(), cyc, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s event: actual %s@%0d expected %s@%0d",
                         e.req, k.name(), cyc, e.kind.name(), e.cyc);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_ni && !done) begin
            check(cnt == exp_cnt[8:0], "R1", "line count", int'(cnt), exp_cnt);
            if (prev_h && !halt_n) see(EV_HALT_LO);
            if (!prev_f && fetch)  see(EV_FETCH_HI);
            if (prev_f && !fetch)  see(EV_FETCH_LO);
            if (abort)             see(EV_ABORT);
            if (!prev_h && halt_n) see(EV_HALT_HI);
            prev_h = halt_n;
            prev_f = fetch;
            // late-start instance: startup may not finish before the cutoff
            if (fetch_l) late_seen = 1'b1;
            if (abort_l) begin
                check(late_seen == late_exp, "R7", "late-window fetch seen",
                      int'(late_seen), int'(late_exp));
                late_seen = 1'b0;
            end
        end
    end

    // Driver: one line of stimulus, expectations pushed to the scoreboard
    task automatic run_line(bit bs, bit ss, bit be, bit se);
        int l0 = cyc;
        int h  = l0 + START + 1;
        int f  = next_ph1(h + up_lat(bs, ss));
        int p  = l0 + ABORT + 1;
        int r  = next_ph1(p + dn_lat(be, se));
        int lh = l0 + LSTART + 1;
        int lf = next_ph1(lh + up_lat(be, se));
        q.push_back('{EV_HALT_LO, h, "R2"});
        if (f <= l0 + ABORT) begin
            q.push_back('{EV_FETCH_HI, f, "R3/R4"});
            q.push_back('{EV_FETCH_LO, p, "R5"});
        end
        q.push_back('{EV_ABORT, p, "R5"});
        q.push_back('{EV_HALT_HI, r, "R6"});
        late_exp = (lf <= l0 + ABORT);
        busy = bs;
        slow = ss;
        repeat (200) @(negedge clk);
        busy = be;
        slow = se;
        repeat (LINE - 200) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state on both instances
        check(halt_n == 1'b1, "R8", "halt during reset", int'(halt_n), 1);
        check(fetch == 1'b0, "R8", "fetch during reset", int'(fetch), 0);
        check(abort == 1'b0, "R8", "abort during reset", int'(abort), 0);
        check(cnt == 9'd0, "R8", "count during reset", int'(cnt), 0);
        check(halt_n_l == 1'b1 && fetch_l == 1'b0 && abort_l == 1'b0 && cnt_l == 9'd0,
              "R8", "late instance reset outputs", int'(halt_n_l), 1);
        rst_ni = 1'b1;
        run_line(0, 0, 0, 0);
        run_line(1, 0, 1, 0);
        run_line(1, 1, 1, 1);   // late instance: startup 9 cannot finish (R7)
        run_line(0, 1, 0, 1);   // slow without busy adds nothing (R3, R6)
        run_line(1, 1, 0, 0);
        run_line(0, 0, 1, 1);
        run_line(1, 0, 0, 1);
        run_line(0, 1, 1, 1);
        run_line(0, 0, 0, 0);
        // R1: line sync mid-line, still before the window start
        repeat (20) @(negedge clk);
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        check(cnt == 9'd0, "R1", "count after sync", int'(cnt), 0);
        repeat (5) @(negedge clk);
        check(cnt == 9'd5, "R1", "count five after sync", int'(cnt), 5);
        check(halt_n == 1'b1, "R2", "no halt before start position", int'(halt_n), 1);
        done = 1'b1;
        while (q.size() != 0) begin
            exp_t e = q.pop_front();
            n_bad++;
            $display("FAIL %s missing event: actual none expected %s@%0d",
                     e.req, e.kind.name(), e.cyc);
        end
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

endmodule